// File: doc/BRIEF.md
# Lane-Striped Pipelined Vector Arithmetic Unit

This unit runs one element-wise integer operation, add or multiply, over two vector registers and writes the results into a third register. The vector register file is split into `LANES` banks. Element i lives in bank (i mod `LANES`) at row (i div `LANES`), and each bank feeds its own pipelined arithmetic lane. In each issue cycle every lane starts one element. Elements 0 to `LANES`-1 go in the first cycle, the next `LANES` elements in the second cycle, and so on until the vector length is covered.

The elements of a vector do not depend on each other, so the lane pipelines carry no hazard checks. An add passes through `ADD_LAT` stages and a multiply through `MUL_LAT` stages. A caller fills the register file through the element load port, starts an operation with a one-cycle `op_start` pulse, waits for the one-cycle `done` pulse, and reads results back through the element read port. Only one operation is in flight at a time.

Top module: `vec_lane_unit`

## Requirements
- R1: While `rst_n` is low and after it is released, `busy` and `done` are 0 until a start is accepted.
- R2: With `op_code`=0 (add), each element i below the vector length of the destination register becomes the sum of element i of the two sources, modulo 2^`DW`.
- R3: With `op_code`=1 (multiply), each element i below the vector length of the destination becomes the low `DW` bits of the product of element i of the two sources.
- R4: Destination elements at or above the vector length keep their earlier value, and so do all other registers.
- R5: A `vec_len` greater than `ELEMS` is treated as `ELEMS`. A `vec_len` of 0 writes nothing: `done` rises at the accepting edge and `busy` stays 0.
- R6: For a non-zero length V, `done` rises ceil(V/`LANES`) + D clock edges after the edge that accepts the start, where D is 1 for add and 6 for multiply. `done` is high for exactly one cycle. `busy` is high from the accepting edge until the cycle in which `done` is high, and is low in that cycle.
- R7: `op_start` is accepted only while `busy` is 0. A start pulse during an operation has no effect on any register or on the timing of `done`.
- R8: The load port writes `ld_data` to element `ld_elem` of register `ld_reg` only while `busy` is 0. A load request while busy changes nothing.
- R9: The destination may be the same register as a source. The results are then the same as with a separate destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_start | input | 1 | Start request, sampled while idle |
| op_code | input | 1 | 0 = add, 1 = multiply |
| vec_len | input | $clog2(ELEMS+1) | Number of elements to process |
| src_a | input | $clog2(NREGS) | First source register index |
| src_b | input | $clog2(NREGS) | Second source register index |
| dst | input | $clog2(NREGS) | Destination register index |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| ld_en | input | 1 | Element load request |
| ld_reg | input | $clog2(NREGS) | Load register index |
| ld_elem | input | $clog2(ELEMS) | Load element index |
| ld_data | input | DW | Load value |
| rd_reg | input | $clog2(NREGS) | Read register index |
| rd_elem | input | $clog2(ELEMS) | Read element index |
| rd_data | output | DW | Combinational read value |

## Verification
The bench uses a length of 9 so that the last issue cycle is only partly filled. A design that wrote a whole beat would overwrite elements 9 to 15, and a design that counted beats wrongly would move `done`. A length of 40 checks clamping, where a wrong design would index past the register or take one extra beat. A length of 0 checks that nothing is written and that completion is immediate. An in-place add catches a design that reads a source after its own result has already been written. During a running multiply the bench also sends a second start and a load request. A design that obeyed either would corrupt an untouched register or shift the `done` cycle.

// File: rtl/vau_pkg.sv
package vau_pkg;

  typedef enum logic {
    VOP_ADD = 1'b0,
    VOP_MUL = 1'b1
  } vop_e;

  // pipeline depth chosen by the operation
  function automatic int vau_depth(vop_e op, int add_lat, int mul_lat);
    return (op == VOP_MUL) ? mul_lat : add_lat;
  endfunction

  // issue cycles needed to cover vl elements over the lanes
  function automatic int vau_beats(int vl, int lanes);
    return (vl + lanes - 1) / lanes;
  endfunction

  // true when the element at (row, lane) lies below the vector length
  function automatic bit vau_live(int row, int lane, int lanes, int vl);
    return (row * lanes + lane) < vl;
  endfunction

endpackage

// File: rtl/vau_bank.sv
module vau_bank #(
  parameter int NREGS = 8,
  parameter int ROWS  = 4,
  parameter int DW    = 16,
  localparam int RW   = $clog2(NREGS),
  localparam int ROWW = $clog2(ROWS)
) (
  input  logic            clk,
  input  logic            we,
  input  logic [RW-1:0]   w_reg,
  input  logic [ROWW-1:0] w_row,
  input  logic [DW-1:0]   w_data,
  input  logic [RW-1:0]   a_reg,
  input  logic [ROWW-1:0] a_row,
  output logic [DW-1:0]   a_data,
  input  logic [RW-1:0]   b_reg,
  input  logic [ROWW-1:0] b_row,
  output logic [DW-1:0]   b_data,
  input  logic [RW-1:0]   o_reg,
  input  logic [ROWW-1:0] o_row,
  output logic [DW-1:0]   o_data
);

  // one lane's slice of every vector register
  logic [DW-1:0] mem [NREGS][ROWS];

  always_ff @(posedge clk) begin
    if (we) mem[w_reg][w_row] <= w_data;
  end

  assign a_data = mem[a_reg][a_row];
  assign b_data = mem[b_reg][b_row];
  assign o_data = mem[o_reg][o_row];

endmodule

// File: rtl/vau_lane_pipe.sv
module vau_lane_pipe
  import vau_pkg::*;
#(
  parameter int DW      = 16,
  parameter int ROWW    = 2,
  parameter int ADD_LAT = 1,
  parameter int MUL_LAT = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_go,
  input  vop_e            in_op,
  input  logic [DW-1:0]   in_a,
  input  logic [DW-1:0]   in_b,
  input  logic [ROWW-1:0] in_row,
  output logic            out_vld,
  output logic [ROWW-1:0] out_row,
  output logic [DW-1:0]   out_data
);

  localparam int DEPTH = (MUL_LAT > ADD_LAT) ? MUL_LAT : ADD_LAT;

  function automatic logic [DW-1:0] lane_alu(vop_e op, logic [DW-1:0] a, logic [DW-1:0] b);
    return (op == VOP_MUL) ? DW'(a * b) : DW'(a + b);
  endfunction

  int               ent;
  logic [DEPTH-1:0] entry;
  logic [DEPTH-1:0] vld_q;
  logic [ROWW-1:0]  row_q [DEPTH];
  logic [DW-1:0]    dat_q [DEPTH];
  logic [DW-1:0]    res;

  // a short operation enters late so both kinds leave at the last stage
  always_comb ent = DEPTH - vau_depth(in_op, ADD_LAT, MUL_LAT);
  assign entry = in_go ? (DEPTH'(1) << ent) : '0;
  assign res   = lane_alu(in_op, in_a, in_b);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= DEPTH'(vld_q << 1) | entry;
  end

  always_ff @(posedge clk) begin
    if (entry[0]) begin
      row_q[0] <= in_row;
      dat_q[0] <= res;
    end
    for (int s = 1; s < DEPTH; s++) begin
      if (entry[s]) begin
        row_q[s] <= in_row;
        dat_q[s] <= res;
      end else begin
        row_q[s] <= row_q[s-1];
        dat_q[s] <= dat_q[s-1];
      end
    end
  end

  assign out_vld  = vld_q[DEPTH-1];
  assign out_row  = row_q[DEPTH-1];
  assign out_data = dat_q[DEPTH-1];

endmodule

// File: rtl/vau_seq.sv
module vau_seq
  import vau_pkg::*;
#(
  parameter int LANES   = 8,
  parameter int ELEMS   = 32,
  parameter int NREGS   = 8,
  parameter int ADD_LAT = 1,
  parameter int MUL_LAT = 6,
  localparam int ROWS   = ELEMS / LANES,
  localparam int ROWW   = $clog2(ROWS),
  localparam int RW     = $clog2(NREGS),
  localparam int VLW    = $clog2(ELEMS + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  vop_e            op_in,
  input  logic [VLW-1:0]  vl_in,
  input  logic [RW-1:0]   a_in,
  input  logic [RW-1:0]   b_in,
  input  logic [RW-1:0]   d_in,
  output logic            busy,
  output logic            done,
  output logic            accept,
  output logic            issue,
  output logic [ROWW-1:0] row,
  output logic [VLW-1:0]  vl_q,
  output vop_e            op_q,
  output logic [RW-1:0]   a_q,
  output logic [RW-1:0]   b_q,
  output logic [RW-1:0]   d_q
);

  localparam int MAXD = (MUL_LAT > ADD_LAT) ? MUL_LAT : ADD_LAT;
  localparam int BW   = $clog2(ROWS + 1);
  localparam int CW   = $clog2(MAXD + 1);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_DRAIN} st_e;

  st_e            st_q;
  logic [BW-1:0]  beat_q;
  logic [BW-1:0]  nbeats_q;
  logic [CW-1:0]  cnt_q;
  logic [VLW-1:0] vl_c;

  assign vl_c   = (int'(vl_in) > ELEMS) ? VLW'(ELEMS) : vl_in;
  assign accept = start && (st_q == S_IDLE);
  assign issue  = (st_q == S_ISSUE);
  assign busy   = (st_q != S_IDLE);
  assign row    = beat_q[ROWW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= S_IDLE;
      done     <= 1'b0;
      beat_q   <= '0;
      nbeats_q <= '0;
      cnt_q    <= '0;
      vl_q     <= '0;
      op_q     <= VOP_ADD;
      a_q      <= '0;
      b_q      <= '0;
      d_q      <= '0;
    end else begin
      done <= 1'b0;
      case (st_q)
        S_IDLE: begin
          if (accept) begin
            vl_q     <= vl_c;
            op_q     <= op_in;
            a_q      <= a_in;
            b_q      <= b_in;
            d_q      <= d_in;
            beat_q   <= '0;
            nbeats_q <= BW'(vau_beats(int'(vl_c), LANES));
            if (vl_c == '0) done <= 1'b1;
            else            st_q <= S_ISSUE;
          end
        end
        S_ISSUE: begin
          if (beat_q == nbeats_q - 1'b1) begin
            st_q  <= S_DRAIN;
            cnt_q <= CW'(vau_depth(op_q, ADD_LAT, MUL_LAT));
          end else begin
            beat_q <= beat_q + 1'b1;
          end
        end
        S_DRAIN: begin
          if (cnt_q == CW'(1)) begin
            st_q <= S_IDLE;
            done <= 1'b1;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/vec_lane_unit.sv
// LANES must be a power of two and ELEMS a multiple of it, with at least two rows.
module vec_lane_unit
  import vau_pkg::*;
#(
  parameter int LANES   = 8,
  parameter int ELEMS   = 32,
  parameter int NREGS   = 8,
  parameter int DW      = 16,
  parameter int ADD_LAT = 1,
  parameter int MUL_LAT = 6,
  localparam int ROWS   = ELEMS / LANES,
  localparam int ROWW   = $clog2(ROWS),
  localparam int LW     = $clog2(LANES),
  localparam int EW     = $clog2(ELEMS),
  localparam int RW     = $clog2(NREGS),
  localparam int VLW    = $clog2(ELEMS + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           op_start,
  input  logic           op_code,
  input  logic [VLW-1:0] vec_len,
  input  logic [RW-1:0]  src_a,
  input  logic [RW-1:0]  src_b,
  input  logic [RW-1:0]  dst,
  output logic           busy,
  output logic           done,
  input  logic           ld_en,
  input  logic [RW-1:0]  ld_reg,
  input  logic [EW-1:0]  ld_elem,
  input  logic [DW-1:0]  ld_data,
  input  logic [RW-1:0]  rd_reg,
  input  logic [EW-1:0]  rd_elem,
  output logic [DW-1:0]  rd_data
);

  // events brought out for the checker
  logic                       seq_accept;
  logic                       seq_issue;
  logic [ROWW-1:0]            seq_row;
  logic [VLW-1:0]             seq_vl;
  vop_e                       seq_op;
  logic [RW-1:0]              a_q, b_q, d_q;
  logic [LANES-1:0]           lane_go;
  logic [LANES-1:0]           pipe_vld;
  logic [LANES-1:0][ROWW-1:0] pipe_row;
  logic [LANES-1:0][DW-1:0]   pipe_data;
  logic [LANES-1:0][DW-1:0]   obs_data;

  vau_seq #(
    .LANES(LANES), .ELEMS(ELEMS), .NREGS(NREGS),
    .ADD_LAT(ADD_LAT), .MUL_LAT(MUL_LAT)
  ) i_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (op_start),
    .op_in  (vop_e'(op_code)),
    .vl_in  (vec_len),
    .a_in   (src_a),
    .b_in   (src_b),
    .d_in   (dst),
    .busy   (busy),
    .done   (done),
    .accept (seq_accept),
    .issue  (seq_issue),
    .row    (seq_row),
    .vl_q   (seq_vl),
    .op_q   (seq_op),
    .a_q    (a_q),
    .b_q    (b_q),
    .d_q    (d_q)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic          ld_hit;
    logic          we;
    logic [DW-1:0] a_data, b_data;

    assign lane_go[k] = seq_issue && vau_live(int'(seq_row), k, LANES, int'(seq_vl));
    assign ld_hit     = ld_en && !busy && (ld_elem[LW-1:0] == LW'(k));
    assign we         = pipe_vld[k] || ld_hit;

    vau_bank #(.NREGS(NREGS), .ROWS(ROWS), .DW(DW)) i_bank (
      .clk    (clk),
      .we     (we),
      .w_reg  (pipe_vld[k] ? d_q : ld_reg),
      .w_row  (pipe_vld[k] ? pipe_row[k] : ld_elem[EW-1:LW]),
      .w_data (pipe_vld[k] ? pipe_data[k] : ld_data),
      .a_reg  (a_q),
      .a_row  (seq_row),
      .a_data (a_data),
      .b_reg  (b_q),
      .b_row  (seq_row),
      .b_data (b_data),
      .o_reg  (rd_reg),
      .o_row  (rd_elem[EW-1:LW]),
      .o_data (obs_data[k])
    );

    vau_lane_pipe #(
      .DW(DW), .ROWW(ROWW), .ADD_LAT(ADD_LAT), .MUL_LAT(MUL_LAT)
    ) i_pipe (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_go    (lane_go[k]),
      .in_op    (seq_op),
      .in_a     (a_data),
      .in_b     (b_data),
      .in_row   (seq_row),
      .out_vld  (pipe_vld[k]),
      .out_row  (pipe_row[k]),
      .out_data (pipe_data[k])
    );
  end

  assign rd_data = obs_data[rd_elem[LW-1:0]];

endmodule

// File: rtl/vau_checker.sv
module vau_checker #(
  parameter int LANES = 8,
  parameter int ROWW  = 2,
  parameter int VLW   = 6
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       busy,
  input logic                       done,
  input logic                       accept,
  input logic [VLW-1:0]             vl_in,
  input logic [LANES-1:0]           pipe_vld,
  input logic [LANES-1:0][ROWW-1:0] pipe_row,
  input logic [VLW-1:0]             vl_q
);

  AST_BUSY_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(accept)); // R7

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6

  AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R6

  AST_EMPTY_FINISHES: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && vl_in == '0) |=> (done && !busy)); // R5

  AST_WRITE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (|pipe_vld) |-> busy); // R8

  for (genvar k = 0; k < LANES; k++) begin : g_chk
    AST_LANE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      pipe_vld[k] |-> ((int'(pipe_row[k]) * LANES + k) < int'(vl_q))); // R4
  end

endmodule

bind vec_lane_unit vau_checker #(.LANES(LANES), .ROWW(ROWW), .VLW(VLW)) i_vau_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .done     (done),
  .accept   (seq_accept),
  .vl_in    (vec_len),
  .pipe_vld (pipe_vld),
  .pipe_row (pipe_row),
  .vl_q     (seq_vl)
);

// File: tb/test_vec_lane_unit.sv
module test_vec_lane_unit;

  localparam int L = 8, E = 32, NR = 8, DW = 16, ADDD = 1, MULD = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_start = 1'b0, op_code = 1'b0;
  logic [5:0] vec_len = '0;
  logic [2:0] src_a = '0, src_b = '0, dst = '0;
  logic busy, done;
  logic ld_en = 1'b0;
  logic [2:0] ld_reg = '0;
  logic [4:0] ld_elem = '0;
  logic [15:0] ld_data = '0;
  logic [2:0] rd_reg = '0;
  logic [4:0] rd_elem = '0;
  logic [15:0] rd_data;

  logic [15:0] model [NR][E];
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  vec_lane_unit i_vec_lane_unit (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_code(op_code),
    .vec_len(vec_len), .src_a(src_a), .src_b(src_b), .dst(dst),
    .busy(busy), .done(done), .ld_en(ld_en), .ld_reg(ld_reg),
    .ld_elem(ld_elem), .ld_data(ld_data), .rd_reg(rd_reg),
    .rd_elem(rd_elem), .rd_data(rd_data)
  );

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] pat(int r, int i, int seed);
    return 16'(((r * 37 + i * 11 + seed) * 97) ^ (i << 7) ^ (r << 12));
  endfunction

  task automatic load_all(int seed);
    for (int r = 0; r < NR; r++) begin
      for (int i = 0; i < E; i++) begin
        @(negedge clk);
        ld_en = 1'b1; ld_reg = 3'(r); ld_elem = 5'(i); ld_data = pat(r, i, seed);
        model[r][i] = pat(r, i, seed);
      end
    end
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic check_reg(int r, string req);
    for (int i = 0; i < E; i++) begin
      rd_reg = 3'(r); rd_elem = 5'(i);
      #1;
      chk(rd_data == model[r][i], req, $sformatf("reg %0d elem %0d", r, i),
          longint'(rd_data), longint'(model[r][i]));
    end
  endtask

  // mode 0: plain, 1: second start while busy, 2: load request while busy
  task automatic run_op(bit op, int a, int b, int d, int vl, int mode, string req);
    int k, vc, exp_k;
    vc = (vl > E) ? E : vl;
    exp_k = (vc == 0) ? 1 : 1 + (vc + L - 1) / L + (op ? MULD : ADDD);
    @(negedge clk);
    op_start = 1'b1; op_code = op; vec_len = 6'(vl);
    src_a = 3'(a); src_b = 3'(b); dst = 3'(d);
    @(negedge clk);
    op_start = 1'b0;
    k = 1;
    chk(busy == (vc != 0), "R6", "busy after accept", longint'(busy), longint'(vc != 0));
    while (!done && k < 100) begin
      @(negedge clk);
      k++;
      if (mode == 1 && k == 2) begin
        op_start = 1'b1; op_code = 1'b0; vec_len = 6'd32; src_a = 3'd0; src_b = 3'd1; dst = 3'd6;
      end
      if (mode == 1 && k == 3) op_start = 1'b0;
      if (mode == 2 && k == 2) begin
        ld_en = 1'b1; ld_reg = 3'd7; ld_elem = 5'd0; ld_data = ~model[7][0];
      end
      if (mode == 2 && k == 3) ld_en = 1'b0;
    end
    chk(k == exp_k, req, "done latency", longint'(k), longint'(exp_k));
    chk(!busy, "R6", "busy low with done", longint'(busy), 0);
    @(negedge clk);
    chk(!done, "R6", "done one cycle", longint'(done), 0);
    for (int i = 0; i < vc; i++)
      model[d][i] = op ? 16'(model[a][i] * model[b][i]) : 16'(model[a][i] + model[b][i]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL R6 watchdog expired actual=%0d expected=%0d", 100000, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk(!busy, "R1", "busy in reset", longint'(busy), 0);
    chk(!done, "R1", "done in reset", longint'(done), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy, "R1", "busy after reset", longint'(busy), 0);
    chk(!done, "R1", "done after reset", longint'(done), 0);
  endtask

  task automatic t_add_full;
    run_op(1'b0, 0, 1, 2, 32, 0, "R6");
    check_reg(2, "R2");
  endtask

  task automatic t_mul_full;
    run_op(1'b1, 3, 4, 5, 32, 0, "R6");
    check_reg(5, "R3");
  endtask

  task automatic t_partial;
    run_op(1'b0, 1, 4, 6, 9, 0, "R6");
    check_reg(6, "R4");
    run_op(1'b1, 2, 5, 7, 1, 0, "R6");
    check_reg(7, "R4");
    check_reg(1, "R4");
  endtask

  task automatic t_len_edges;
    run_op(1'b1, 1, 2, 0, 0, 0, "R5");
    check_reg(0, "R5");
    run_op(1'b0, 5, 6, 1, 40, 0, "R5");
    check_reg(1, "R5");
  endtask

  task automatic t_inplace;
    run_op(1'b0, 3, 4, 3, 20, 0, "R6");
    check_reg(3, "R9");
    run_op(1'b1, 4, 4, 4, 32, 0, "R6");
    check_reg(4, "R9");
  endtask

  task automatic t_start_busy;
    run_op(1'b1, 0, 1, 2, 32, 1, "R7");
    check_reg(6, "R7");
    check_reg(2, "R7");
  endtask

  task automatic t_load_busy;
    run_op(1'b1, 5, 2, 4, 32, 2, "R8");
    check_reg(7, "R8");
    check_reg(4, "R8");
  endtask

  initial begin
    t_reset();
    load_all(1);
    t_add_full();
    t_mul_full();
    t_partial();
    t_len_edges();
    t_inplace();
    t_start_busy();
    t_load_busy();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule